// File: doc/BRIEF.md
# Write-Only Serial Configuration Register Bank

This block is a three-wire serial slave that only accepts writes. A host pulls the active-low enable low, drives a data bit on the data line and pulses the serial clock once for each bit. Sixteen bits make a frame. The most significant bit comes first. The top four bits pick a target register and the low twelve bits are its new contents. The block holds ten 12-bit configuration registers and presents them side by side on one wide parallel output.

All three serial lines pass through a synchronizer into the system clock domain, where edges are detected. A bit counter stops after sixteen bits. Nothing is written until the enable returns high, and then only when the frame is complete. A short frame leaves every register as it was. A one-cycle flag marks each complete frame.

Top module: `serwr_regbank`

## Requirements
- R1: After the asynchronous active-low reset, all ten registers read zero and the frame-complete flag is low.
- R2: A complete frame is sampled on rising serial-clock edges, most significant bit first. Frame bits 15:12 form the address and bits 11:0 form the data. When the enable rises, register[address] takes the data, which appears on `regs_o[address*12 +: 12]`.
- R3: Serial-clock pulses after the sixteenth in one frame have no effect on the stored word.
- R4: If the enable rises after fewer than sixteen bits, the frame is dropped and no register changes.
- R5: A commit changes only the addressed register. All other registers keep their values.
- R6: `done_o` is high for exactly one system-clock cycle for each complete frame, whatever its address.
- R7: The bit count restarts from zero for every frame, so a full frame that follows an aborted frame is written correctly.
- R8: A complete frame whose address is 10 through 15 updates no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sen_n | input | 1 | Serial frame enable, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| regs_o | output | 120 | Ten 12-bit registers; register k is at bits k*12+11 : k*12 |
| done_o | output | 1 | One-cycle pulse for each complete frame |

## Verification
Each serial line goes through two synchronizer flops and then one edge-detect flop. A register write and the `done_o` pulse therefore show up on the third system-clock edge after the enable is released. The bench holds every serial level for four system clocks so that each edge is seen. It compares the register outputs eight cycles after each release, which is well after that third edge. `done_o` pulses are counted continuously, and each frame's count is compared against the number of complete frames the bench expects by then.

// File: rtl/serwr_regbank.sv
module serwr_regbank #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 12,
  parameter int NUM_REGS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sen_n,
  input  logic                       sclk,
  input  logic                       sdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       done_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sen_sy, sclk_sy, sd_sy;
  logic                   sen_d, sclk_d;
  logic [CNT_W-1:0]       cnt;
  logic [FRAME_W-1:0]     sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sen_sy  <= '1;
      sclk_sy <= '0;
      sd_sy   <= '0;
      sen_d   <= 1'b1;
      sclk_d  <= 1'b0;
    end else begin
      sen_sy  <= {sen_sy[SYNC_STAGES-2:0], sen_n};
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      sd_sy   <= {sd_sy[SYNC_STAGES-2:0], sdata};
      sen_d   <= sen_sy[SYNC_STAGES-1];
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end

  wire sen_s     = sen_sy[SYNC_STAGES-1];
  wire sclk_rise = sclk_sy[SYNC_STAGES-1] & ~sclk_d;
  wire sen_rise  = sen_s & ~sen_d;
  wire full      = (cnt == CNT_W'(FRAME_W));
  wire commit    = sen_rise & full;
  wire [ADDR_W-1:0] addr = sh[FRAME_W-1 -: ADDR_W];
  wire [DATA_W-1:0] data = sh[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sen_s) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sclk_rise && !full) begin
      cnt <= cnt + 1'b1;
      sh  <= {sh[FRAME_W-2:0], sd_sy[SYNC_STAGES-1]};
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        regs_o[g*DATA_W +: DATA_W] <= '0;
      else if (commit && addr == ADDR_W'(g))
        regs_o[g*DATA_W +: DATA_W] <= data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= commit;
endmodule

// File: rtl/serwr_regbank_chk.sv
module serwr_regbank_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 10,
  parameter int CNT_W    = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sen_s,
  input logic [CNT_W-1:0]           cnt,
  input logic [ADDR_W+DATA_W-1:0]   sh,
  input logic [NUM_REGS*DATA_W-1:0] regs,
  input logic                       done
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  p_only_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs != $past(regs)) |-> done);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> cnt == '0);

  p_high_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int'($past(sh[FRAME_W-1 -: ADDR_W])) >= NUM_REGS) |-> regs == $past(regs));
endmodule

bind serwr_regbank serwr_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_s(sen_s), .cnt(cnt),
  .sh(sh), .regs(regs_o), .done(done_o)
);

// File: tb/serwr_regbank_tb.sv
module serwr_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 10;
  localparam int DW = 12;

  logic clk = 0, rst_n = 0, sen_n = 1, sclk = 0, sdata = 0;
  logic [NR*DW-1:0] regs_o;
  logic done_o;

  int n_chk = 0, n_bad = 0, n_done = 0, exp_done = 0;
  logic [DW-1:0] model [NR];

  serwr_regbank u_dut (.clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk),
                       .sdata(sdata), .regs_o(regs_o), .done_o(done_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && done_o) n_done++;

  function automatic logic [NR*DW-1:0] pack_model();
    logic [NR*DW-1:0] v;
    for (int k = 0; k < NR; k++) v[k*DW +: DW] = model[k];
    return v;
  endfunction

  task automatic check(string req, logic [NR*DW-1:0] act, logic [NR*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(int nbits, logic [15:0] word);
    sen_n = 0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? word[15-i] : 1'($urandom);
      wait_clk(4);
      sclk = 1;
      wait_clk(4);
      sclk = 0;
    end
    wait_clk(4);
    sen_n = 1;
    if (nbits >= 16) begin
      exp_done++;
      if (word[15:12] < NR) model[word[15:12]] = word[11:0];
    end
    wait_clk(8);
    @(negedge clk);
  endtask

  task automatic frame_check(string req);
    check(req, regs_o, pack_model());
    check({req, " done"}, NR*DW'(n_done), NR*DW'(exp_done));
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < NR; k++) model[k] = '0;
    wait_clk(3);
    @(negedge clk);
    check("R1 regs", regs_o, '0);
    check("R1 done", NR*DW'(done_o), '0);
    rst_n = 1;
    wait_clk(4);

    send(16, 16'h0ABC); frame_check("R2");
    send(16, 16'h9123); frame_check("R5");
    send(20, 16'h3F0F); frame_check("R3");
    send(9,  16'h1777); frame_check("R4");
    send(16, 16'h1555); frame_check("R7");
    send(16, 16'hA999); frame_check("R8 addr10");
    send(16, 16'hFFFF); frame_check("R8 addr15");
    send(15, 16'h2FFF); frame_check("R4 15bits");
    send(16, 16'h2001); frame_check("R6");

    for (int t = 0; t < 40; t++) begin
      int sel = $urandom_range(0, 9);
      int nb  = (sel < 6) ? 16 : (sel < 8) ? $urandom_range(1, 15) : $urandom_range(17, 21);
      logic [15:0] w = 16'($urandom);
      send(nb, w);
      frame_check(nb < 16 ? "R4 rnd" : nb > 16 ? "R3 rnd" : (w[15:12] >= NR ? "R8 rnd" : "R2 rnd"));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule